// File: doc/BRIEF.md
# Multiplexed Seven-Segment Digit Scanner

This block drives a time-multiplexed display of up to four common-anode digits. A prescaler divides the system clock into subslot ticks. Sixteen subslots make one digit slot, and the block steps through the enabled digits one slot at a time. During each slot it presents eight segment lines (a to g plus a decimal point) for the digit being shown. It raises that digit's strobe for the first N subslots of the slot, where N is a 4-bit brightness value.

A command receiver elsewhere in the chip supplies the per-digit data bytes, the decode switch, the index of the last scanned digit, the brightness value and a global mode. The data byte either passes straight to the segments or goes through a character decoder. The mode can blank the display, force all segments on, or put the display to sleep, without altering any of the supplied settings. Segment data, digit index and brightness are captured only at slot boundaries, so a glyph never bleeds into a neighbouring digit.

Top module: `seg_scan_driver`

## Requirements
- R1: Only digits 0 through `last_digit_i` (0..3) are scanned in rotation. The strobes of higher digits never go active.
- R2: An enabled digit's strobe is active for exactly N×PRESCALE clocks of its 16×PRESCALE-clock slot, where N is `duty_i`. N = 0 keeps every strobe off. PRESCALE is CLK_HZ / (SCAN_HZ × 4 × 16), which gives about 480 scans per second at the default settings.
- R3: At most one bit of `dig_o` is active at any time.
- R4: With `decode_i` = 0, bit i of a data byte drives `seg_o[i]` directly, with a 1 lighting the segment. The mapping is a=0, b=1, c=2, d=3, e=4, f=5, g=6 and decimal point=7.
- R5: With `decode_i` = 1, bits 5..4 = 00 select hexadecimal glyphs from bits 3..0. Bit 6 alone drives the decimal point (`seg_o[7]`) and bit 7 is ignored. Any other value of bits 5..4 gives a blank glyph, including code 0000 with bits 5..4 = 01. The glyphs are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, B=7C, C=39, D=5E, E=79, F=71.
- R6: An all-zero data byte in decode mode shows the numeral 0 (segments 3F).
- R7: Mode 1 (blank) and mode 3 (standby) hold `seg_o` and `dig_o` at zero from the clock after the mode appears. Returning to mode 0 (run) restores the display from the unchanged settings.
- R8: Mode 2 (all on) drives every segment line high while the strobes keep their duty-gated scan.
- R9: `seg_o` changes only at digit-slot boundaries, never while one digit's strobe is held.
- R10: During reset both outputs are zero, and the first slot after reset stays dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 run, 1 blank, 2 all on, 3 standby |
| decode_i | input | 1 | 1 routes data through the character decoder |
| last_digit_i | input | 2 | Index of the last digit scanned |
| duty_i | input | 4 | Lit subslots per digit slot (0..15) |
| digit_data_i | input | 32 | Data byte of digit d at bits 8d+7..8d |
| seg_o | output | 8 | Segment lines, bit 0 = a up to bit 7 = decimal point |
| dig_o | output | 4 | Digit strobes, one bit per digit |

## Verification
A settings change reaches the outputs only at the next slot boundary plus one output-register clock. A mode change shows up one clock after it is applied. The bench therefore waits two full four-digit scans after each change before it observes anything. It then samples on the falling edge for exactly one scan period of the programmed length, (K+1)×16×PRESCALE clocks. The pattern is periodic with that length, so the number of strobe-active clocks per digit and the segments seen under each strobe are known exactly, whatever the phase at which the window starts.

// File: rtl/scan_pkg.sv
package scan_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'd0,
      MODE_DARK  = 2'd1,
      MODE_LAMP  = 2'd2,
      MODE_SLEEP = 2'd3
   } scan_mode_e;

   localparam int SEG_W = 8;
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
   parameter int PRESCALE = 4,
   parameter int SUB_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [SUB_W-1:0] sub_o,
   output logic             slot_end_o
);
   localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

   logic tick;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         logic [PS_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (div_q == PS_W'(PRESCALE - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign tick = (div_q == PS_W'(PRESCALE - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_o <= '0;
      end else if (tick) begin
         sub_o <= sub_o + 1'b1;
      end
   end

   assign slot_end_o = tick && (sub_o == SUB_MAX);
endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder (
   input  logic [7:0] data_i,
   input  logic       decode_i,
   output logic [7:0] seg_o
);
   logic [6:0] hex_shape;

   always_comb begin
      case (data_i[3:0])
         4'h0: hex_shape = 7'h3F;
         4'h1: hex_shape = 7'h06;
         4'h2: hex_shape = 7'h5B;
         4'h3: hex_shape = 7'h4F;
         4'h4: hex_shape = 7'h66;
         4'h5: hex_shape = 7'h6D;
         4'h6: hex_shape = 7'h7D;
         4'h7: hex_shape = 7'h07;
         4'h8: hex_shape = 7'h7F;
         4'h9: hex_shape = 7'h6F;
         4'hA: hex_shape = 7'h77;
         4'hB: hex_shape = 7'h7C;
         4'hC: hex_shape = 7'h39;
         4'hD: hex_shape = 7'h5E;
         4'hE: hex_shape = 7'h79;
         default: hex_shape = 7'h71;
      endcase
   end

   always_comb begin
      if (!decode_i) begin
         seg_o = data_i;
      end else if (data_i[5:4] == 2'b00) begin
         seg_o = {data_i[6], hex_shape};
      end else begin
         seg_o = {data_i[6], 7'h00};
      end
   end
endmodule

// File: rtl/digit_sequencer.sv
module digit_sequencer #(
   parameter int NUM_DIGITS = 4,
   parameter int DUTY_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       slot_end_i,
   input  logic [DUTY_W-1:0]          sub_i,
   input  logic [$clog2(NUM_DIGITS)-1:0] last_digit_i,
   input  logic [DUTY_W-1:0]          duty_i,
   input  logic                       decode_i,
   input  logic [NUM_DIGITS*8-1:0]    digit_data_i,
   output logic [$clog2(NUM_DIGITS)-1:0] cur_idx_o,
   output logic [7:0]                 seg_q_o,
   output logic [DUTY_W-1:0]          duty_q_o,
   output logic                       lit_o
);
   localparam int IDX_W = $clog2(NUM_DIGITS);

   logic [IDX_W-1:0] next_idx;
   logic [7:0]       next_byte;
   logic [7:0]       next_seg;

   always_comb begin
      if (cur_idx_o >= last_digit_i) begin
         next_idx = '0;
      end else begin
         next_idx = cur_idx_o + 1'b1;
      end
   end

   assign next_byte = digit_data_i[next_idx*8 +: 8];

   glyph_decoder u_glyph (
      .data_i   (next_byte),
      .decode_i (decode_i),
      .seg_o    (next_seg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx_o <= IDX_W'(NUM_DIGITS - 1);
         seg_q_o   <= '0;
         duty_q_o  <= '0;
      end else if (slot_end_i) begin
         cur_idx_o <= next_idx;
         seg_q_o   <= next_seg;
         duty_q_o  <= duty_i;
      end
   end

   assign lit_o = (sub_i < duty_q_o);
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver #(
   parameter int CLK_HZ     = 50_000_000,
   parameter int SCAN_HZ    = 480,
   parameter int NUM_DIGITS = 4,
   parameter int DUTY_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    mode_i,
   input  logic                          decode_i,
   input  logic [$clog2(NUM_DIGITS)-1:0] last_digit_i,
   input  logic [DUTY_W-1:0]             duty_i,
   input  logic [NUM_DIGITS*8-1:0]       digit_data_i,
   output logic [scan_pkg::SEG_W-1:0]    seg_o,
   output logic [NUM_DIGITS-1:0]         dig_o
);
   import scan_pkg::*;

   localparam int SUBSLOTS = 1 << DUTY_W;
   localparam int PRESCALE = CLK_HZ / (SCAN_HZ * NUM_DIGITS * SUBSLOTS);
   localparam int IDX_W    = $clog2(NUM_DIGITS);

   generate
      if (PRESCALE < 1) begin : g_bad_rate
         $error("seg_scan_driver: CLK_HZ too low for SCAN_HZ");
      end
      if (NUM_DIGITS < 2 || (1 << IDX_W) != NUM_DIGITS) begin : g_bad_digits
         $error("seg_scan_driver: NUM_DIGITS must be a power of two >= 2");
      end
      if (DUTY_W < 1) begin : g_bad_duty
         $error("seg_scan_driver: DUTY_W must be positive");
      end
   endgenerate

   logic [DUTY_W-1:0] sub;
   logic              slot_end;
   logic [IDX_W-1:0]  cur_idx;
   logic [7:0]        seg_q;
   logic [DUTY_W-1:0] duty_q;
   logic              lit;
   logic [NUM_DIGITS-1:0] strobe;
   scan_mode_e        mode;

   assign mode = scan_mode_e'(mode_i);

   scan_timer #(.PRESCALE(PRESCALE), .SUB_W(DUTY_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .sub_o      (sub),
      .slot_end_o (slot_end)
   );

   digit_sequencer #(.NUM_DIGITS(NUM_DIGITS), .DUTY_W(DUTY_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_end_i   (slot_end),
      .sub_i        (sub),
      .last_digit_i (last_digit_i),
      .duty_i       (duty_i),
      .decode_i     (decode_i),
      .digit_data_i (digit_data_i),
      .cur_idx_o    (cur_idx),
      .seg_q_o      (seg_q),
      .duty_q_o     (duty_q),
      .lit_o        (lit)
   );

   generate
      for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_strobe
         assign strobe[d] = lit && (cur_idx == IDX_W'(d));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_o <= '0;
         dig_o <= '0;
      end else begin
         case (mode)
            MODE_RUN: begin
               seg_o <= seg_q;
               dig_o <= strobe;
            end
            MODE_LAMP: begin
               seg_o <= '1;
               dig_o <= strobe;
            end
            default: begin
               seg_o <= '0;
               dig_o <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
   parameter int NUM_DIGITS = 4,
   parameter int DUTY_W     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            mode_i,
   input logic [7:0]            seg_o,
   input logic [NUM_DIGITS-1:0] dig_o,
   input logic [7:0]            seg_q,
   input logic                  slot_end,
   input logic [DUTY_W-1:0]     duty_q
);
   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dig_o));

   assert_dark_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd1 || mode_i == 2'd3) |=> (seg_o == 8'h00 && dig_o == '0));

   assert_lamp_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd2) |=> (seg_o == 8'hFF));

   assert_zero_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |=> (dig_o == '0));

   assert_slot_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(seg_q) |-> $past(slot_end));
endmodule

bind seg_scan_driver scan_checker #(.NUM_DIGITS(NUM_DIGITS), .DUTY_W(DUTY_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_i   (mode_i),
   .seg_o    (seg_o),
   .dig_o    (dig_o),
   .seg_q    (seg_q),
   .slot_end (slot_end),
   .duty_q   (duty_q)
);

// File: tb/sim_seg_scan_driver.sv
module sim_seg_scan_driver;
   localparam int P    = 3;
   localparam int SLOT = 16 * P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic        decode_i = 1'b1;
   logic [1:0]  last_digit_i = 2'd3;
   logic [3:0]  duty_i = 4'd15;
   logic [31:0] digit_data_i = '0;
   logic [7:0]  seg_o;
   logic [3:0]  dig_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   seg_scan_driver #(.CLK_HZ(480 * 64 * P), .SCAN_HZ(480)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_i),
      .decode_i     (decode_i),
      .last_digit_i (last_digit_i),
      .duty_i       (duty_i),
      .digit_data_i (digit_data_i),
      .seg_o        (seg_o),
      .dig_o        (dig_o)
   );

   function automatic logic [7:0] exp_glyph(logic [7:0] v, bit dec);
      logic [6:0] s;
      if (!dec) return v;
      if (v[5:4] != 2'b00) return {v[6], 7'h00};
      case (v[3:0])
         4'h0: s = 7'h3F; 4'h1: s = 7'h06; 4'h2: s = 7'h5B; 4'h3: s = 7'h4F;
         4'h4: s = 7'h66; 4'h5: s = 7'h6D; 4'h6: s = 7'h7D; 4'h7: s = 7'h07;
         4'h8: s = 7'h7F; 4'h9: s = 7'h6F; 4'hA: s = 7'h77; 4'hB: s = 7'h7C;
         4'hC: s = 7'h39; 4'hD: s = 7'h5E; 4'hE: s = 7'h79; default: s = 7'h71;
      endcase
      return {v[6], s};
   endfunction

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_case(string seg_req, logic [1:0] md, bit dec,
                           logic [1:0] k, logic [3:0] n, logic [31:0] data);
      int cnt [4];
      int mis = 0;
      int ghost = 0;
      logic [7:0] prev_seg;
      logic [3:0] prev_dig;
      logic [7:0] e;
      @(negedge clk);
      mode_i = md; decode_i = dec; last_digit_i = k; duty_i = n; digit_data_i = data;
      repeat (2 * 4 * SLOT + 4) @(negedge clk);
      for (int d = 0; d < 4; d++) cnt[d] = 0;
      prev_seg = seg_o; prev_dig = dig_o;
      for (int c = 0; c < (int'(k) + 1) * SLOT; c++) begin
         @(negedge clk);
         for (int d = 0; d < 4; d++) begin
            if (dig_o[d]) begin
               cnt[d]++;
               e = (md == 2'd2) ? 8'hFF : exp_glyph(data[d*8 +: 8], dec);
               if (seg_o !== e) mis++;
            end
         end
         if ((md == 2'd1 || md == 2'd3) && seg_o != 8'h00) mis++;
         if (md == 2'd0 && dig_o != 0 && dig_o == prev_dig && seg_o != prev_seg) ghost++;
         prev_seg = seg_o; prev_dig = dig_o;
      end
      for (int d = 0; d < 4; d++) begin
         if (md == 2'd1 || md == 2'd3)  chk("R7 strobe count", cnt[d], 0);
         else if (d > int'(k))          chk("R1 unused strobe", cnt[d], 0);
         else                           chk("R2 lit clocks", cnt[d], int'(n) * P);
      end
      chk(seg_req, mis, 0);
      chk("R9 mid-slot change", ghost, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lit;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R10 reset seg", int'(seg_o), 0);
      chk("R10 reset dig", int'(dig_o), 0);
      rst_n = 1'b1;
      lit = 0;
      for (int c = 0; c < SLOT - 1; c++) begin
         @(negedge clk);
         if (dig_o != 0) lit++;
      end
      chk("R10 first slot dark", lit, 0);

      run_case("R6 initial zero data", 2'd0, 1'b1, 2'd3, 4'd15, 32'h0);
      run_case("R5 hex glyphs", 2'd0, 1'b1, 2'd3, 4'd8, 32'h0F4A_0B09);
      run_case("R5 dp and blank pages", 2'd0, 1'b1, 2'd3, 4'd15, 32'hE3_90_10_4C);
      run_case("R4 raw segments", 2'd0, 1'b0, 2'd3, 4'd15, 32'h80_01_55_AA);
      run_case("R4 raw two digits", 2'd0, 1'b0, 2'd1, 4'd1, 32'h12_34_56_78);
      run_case("R2 zero duty", 2'd0, 1'b1, 2'd3, 4'd0, 32'h0123_4567);
      run_case("R1 single digit", 2'd0, 1'b1, 2'd0, 4'd7, 32'h0000_0005);
      run_case("R7 blank", 2'd1, 1'b1, 2'd3, 4'd15, 32'h0A0B_0C0D);
      run_case("R7 resume after blank", 2'd0, 1'b1, 2'd3, 4'd15, 32'h0A0B_0C0D);
      run_case("R7 standby", 2'd3, 1'b0, 2'd2, 4'd9, 32'hFFFF_FFFF);
      run_case("R8 all on", 2'd2, 1'b1, 2'd2, 4'd5, 32'h1010_1010);

      for (int i = 0; i < 8; i++) begin
         logic [1:0] md;
         md = ($urandom % 4 == 0) ? 2'd2 : 2'd0;
         run_case(md == 2'd2 ? "R8 random" : "R4 R5 random", md, 1'($urandom),
                  2'($urandom), 4'($urandom), $urandom);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule